// File: doc/BRIEF.md
# Backplane Bus Role Controller

This block lets one processor board serve either as the backplane bus arbiter or as one of three auxiliary processors, chosen by a strapped 2-bit role code. Depending on that role it chooses where the local DMA grant comes from, whether the board drives the select-acknowledge line, whether it drives or receives the backplane initialize signal, and how the interrupt-acknowledge daisy chain is passed on. It also masks the backplane interrupt levels that only the arbiter may service.

Every signal that arrives from the backplane passes through a synchronizer bank before any logic uses it. When this board is the arbiter, the backplane initialize output is stretched by a counter, so each trigger produces a pulse of at least a fixed length. When it is an auxiliary, a received initialize is turned into an internal reset. The arbitration algorithm itself lives outside the block. The block only enables or bypasses it and takes in its grant.

Top module: `bus_role_ctrl`

## Requirements
- R1: Role code 0 selects the arbiter role and drives `arb_en_o` high. Codes 1, 2 and 3 select auxiliaries 1 to 3 and drive `arb_en_o` low.
- R2: `bp_dmr_o` follows `dma_req_i` in the same cycle in every role.
- R3: In the arbiter role `local_gnt_o` equals `arb_gnt_i` in the same cycle. In an auxiliary role it equals `bp_dmg_in_i` delayed by exactly two clock edges, and `arb_gnt_i` has no effect on it.
- R4: `bp_sack_o` is never high in the arbiter role. In an auxiliary role it is high exactly when the synchronized grant-in and `dma_req_i` are both high.
- R5: In the arbiter role, a one-cycle pulse on `bir_wr_i` makes `bp_init_o` rise at the next clock edge and stay high for exactly INIT_HOLD cycles. A new pulse during that time restarts the count.
- R6: In the arbiter role, `bp_init_o` is high from the third edge after `bp_dcok_i` falls, for as long as DC-OK stays low. After the synchronized DC-OK rises, it stays high for INIT_HOLD + 1 more cycles, counted from the sample after the first edge following the rise.
- R7: In an auxiliary role `bp_init_o` stays low, whatever `bir_wr_i` and `bp_dcok_i` do.
- R8: `int_rst_o` is high whenever the synchronized DC-OK is low, in either role. It is also high while `bp_init_o` is high in the arbiter role, and while the synchronized `bp_init_in_i` is high in an auxiliary role. It is low otherwise.
- R9: In the arbiter role `bp_iak_out_o` equals `arb_iak_i` in the same cycle. In an auxiliary role it equals `bp_iak_in_i` delayed by two edges, and `arb_iak_i` has no effect on it.
- R10: `irq_pend_o[N_LOC_IRQ-1:0]` passes the local sources through in every role: bit 0 interval timer, bit 1 console, bit 2 doorbell. Bit N_LOC_IRQ+i carries backplane level 4+i, after synchronization, and only in the arbiter role; in an auxiliary role those bits read 0.
- R11: While `rst_ni` is low, every synchronizer stage holds 0. As a result `int_rst_o` is high, `bp_init_o` and `bp_sack_o` are low, and an auxiliary's `local_gnt_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| role_code_i | input | 2 | Strapped role code |
| dma_req_i | input | 1 | Local DMA request |
| arb_gnt_i | input | 1 | Grant from the on-board arbitration logic |
| arb_iak_i | input | 1 | Arbiter is responding to a backplane interrupt |
| bir_wr_i | input | 1 | Write strobe of the bus-initialize register |
| loc_irq_i | input | N_LOC_IRQ (3) | Local interrupt sources: timer, console, doorbell |
| bp_dmg_in_i | input | 1 | Backplane DMA grant in |
| bp_iak_in_i | input | 1 | Backplane interrupt-acknowledge in |
| bp_init_in_i | input | 1 | Backplane initialize, as received |
| bp_dcok_i | input | 1 | Backplane DC-OK |
| bp_irq_i | input | N_BP_IRQ (4) | Backplane interrupt levels 4 and up |
| bp_dmr_o | output | 1 | Backplane DMA request |
| arb_en_o | output | 1 | Enable for the on-board arbitration logic |
| local_gnt_o | output | 1 | DMA grant to the local CPU |
| bp_sack_o | output | 1 | Backplane select acknowledge |
| bp_init_o | output | 1 | Backplane initialize drive |
| bp_iak_out_o | output | 1 | Backplane interrupt-acknowledge out |
| int_rst_o | output | 1 | Internal reset of the board |
| irq_pend_o | output | N_LOC_IRQ+N_BP_IRQ (7) | Interrupt requests the CPU may service |

## Verification
Most state errors here surface quickly. A wrong synchronizer stage or reset value moves grant, acknowledge or interrupt edges one cycle early or late, or shows an auxiliary grant during reset, and this appears within two clocks of the input change. A miscounting stretch counter changes the length of the `bp_init_o` pulse, which becomes visible only at the end of a pulse. That is INIT_HOLD cycles after the write strobe, or INIT_HOLD+1 cycles after DC-OK returns. A role-decode fault shows at once as a grant, acknowledge or interrupt routed from the wrong source. The bench therefore sweeps every role against every combination of the routed inputs, and times each pulse edge separately.

// File: rtl/brc_pkg.sv
package brc_pkg;
   typedef enum logic [1:0] {
      ROLE_ARB  = 2'd0,
      ROLE_AUX1 = 2'd1,
      ROLE_AUX2 = 2'd2,
      ROLE_AUX3 = 2'd3
   } role_e;

   function automatic logic role_is_arb(input logic [1:0] code);
      return role_e'(code) == ROLE_ARB;
   endfunction
endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("brc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/brc_init_stretch.sv
module brc_init_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enable_i,
   input  logic trigger_i,
   output logic active_o
);
   if (HOLD < 1) begin : g_bad_hold
      $error("brc_init_stretch: HOLD must be at least 1");
   end

   localparam int CNT_W = $clog2(HOLD + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!enable_i)       cnt_q <= '0;
      else if (trigger_i)       cnt_q <= LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = enable_i && (cnt_q != '0);
endmodule

// File: rtl/brc_irq_mask.sv
module brc_irq_mask #(
   parameter int N_LOC = 3,
   parameter int N_BP  = 4
) (
   input  logic [N_LOC-1:0]      loc_i,
   input  logic [N_BP-1:0]       bp_i,
   input  logic                  bp_allow_i,
   output logic [N_LOC+N_BP-1:0] pend_o
);
   assign pend_o[N_LOC-1:0] = loc_i;

   for (genvar i = 0; i < N_BP; i++) begin : g_bp
      assign pend_o[N_LOC+i] = bp_i[i] & bp_allow_i;
   end
endmodule

// File: rtl/bus_role_ctrl.sv
module bus_role_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int INIT_HOLD   = 16,
   parameter int N_LOC_IRQ   = 3,
   parameter int N_BP_IRQ    = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [1:0]                    role_code_i,
   input  logic                          dma_req_i,
   input  logic                          arb_gnt_i,
   input  logic                          arb_iak_i,
   input  logic                          bir_wr_i,
   input  logic [N_LOC_IRQ-1:0]          loc_irq_i,
   input  logic                          bp_dmg_in_i,
   input  logic                          bp_iak_in_i,
   input  logic                          bp_init_in_i,
   input  logic                          bp_dcok_i,
   input  logic [N_BP_IRQ-1:0]           bp_irq_i,
   output logic                          bp_dmr_o,
   output logic                          arb_en_o,
   output logic                          local_gnt_o,
   output logic                          bp_sack_o,
   output logic                          bp_init_o,
   output logic                          bp_iak_out_o,
   output logic                          int_rst_o,
   output logic [N_LOC_IRQ+N_BP_IRQ-1:0] irq_pend_o
);
   import brc_pkg::*;

   localparam int N_CTRL = 4;
   localparam int SYNC_W = N_CTRL + N_BP_IRQ;

   if (N_LOC_IRQ < 1 || N_BP_IRQ < 1) begin : g_bad_irq
      $error("bus_role_ctrl: interrupt source counts must be at least 1");
   end

   // Synchronizer bank: {dcok, init_in, iak_in, dmg_in, irq levels}
   logic [SYNC_W-1:0] raw_bp, syn_bp;
   logic              dcok_s, init_in_s, iak_in_s, dmg_in_s;
   logic [N_BP_IRQ-1:0] irq_s;

   assign raw_bp = {bp_dcok_i, bp_init_in_i, bp_iak_in_i, bp_dmg_in_i, bp_irq_i};

   brc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_bp),
      .q_o   (syn_bp)
   );

   assign {dcok_s, init_in_s, iak_in_s, dmg_in_s, irq_s} = syn_bp;

   // Role decode
   logic is_arb;
   assign is_arb   = role_is_arb(role_code_i);
   assign arb_en_o = is_arb;

   // DMA path: both roles request, grant source depends on role
   assign bp_dmr_o    = dma_req_i;
   assign local_gnt_o = is_arb ? arb_gnt_i : dmg_in_s;
   assign bp_sack_o   = !is_arb && dmg_in_s && dma_req_i;

   // Backplane initialize: driven only by the arbiter, stretched
   logic init_trig, init_active;
   assign init_trig = bir_wr_i || !dcok_s;

   brc_init_stretch #(.HOLD(INIT_HOLD)) u_init (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enable_i (is_arb),
      .trigger_i(init_trig),
      .active_o (init_active)
   );

   assign bp_init_o = init_active;
   assign int_rst_o = !dcok_s || (is_arb ? init_active : init_in_s);

   // Interrupt acknowledge daisy chain
   assign bp_iak_out_o = is_arb ? arb_iak_i : iak_in_s;

   // Interrupt source qualification
   brc_irq_mask #(.N_LOC(N_LOC_IRQ), .N_BP(N_BP_IRQ)) u_irq (
      .loc_i     (loc_irq_i),
      .bp_i      (irq_s),
      .bp_allow_i(is_arb),
      .pend_o    (irq_pend_o)
   );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
   parameter int N_LOC_IRQ = 3,
   parameter int N_BP_IRQ  = 4
) (
   input logic                          clk_i,
   input logic                          rst_ni,
   input logic [1:0]                    role_code_i,
   input logic                          dma_req_i,
   input logic                          arb_gnt_i,
   input logic                          arb_iak_i,
   input logic                          bir_wr_i,
   input logic [N_LOC_IRQ-1:0]          loc_irq_i,
   input logic                          bp_dmr_o,
   input logic                          arb_en_o,
   input logic                          local_gnt_o,
   input logic                          bp_sack_o,
   input logic                          bp_init_o,
   input logic                          bp_iak_out_o,
   input logic                          int_rst_o,
   input logic [N_LOC_IRQ+N_BP_IRQ-1:0] irq_pend_o
);
   localparam int TOP = N_LOC_IRQ + N_BP_IRQ - 1;

   a_r1_role_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_en_o == (role_code_i == 2'd0));

   a_r2_req_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bp_dmr_o == dma_req_i);

   a_r3_arb_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_code_i == 2'd0) |-> (local_gnt_o == arb_gnt_i));

   a_r4_arb_no_sack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_code_i == 2'd0) |-> !bp_sack_o);

   a_r4_sack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bp_sack_o |-> (dma_req_i && local_gnt_o));

   a_r5_write_starts_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_code_i == 2'd0 && bir_wr_i) |=> (bp_init_o || role_code_i != 2'd0));

   a_r7_aux_no_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_code_i != 2'd0) |-> !bp_init_o);

   a_r8_init_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bp_init_o |-> int_rst_o);

   a_r9_arb_iak: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_code_i == 2'd0) |-> (bp_iak_out_o == arb_iak_i));

   a_r10_local_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_pend_o[N_LOC_IRQ-1:0] == loc_irq_i);

   a_r10_aux_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_code_i != 2'd0) |-> (irq_pend_o[TOP:N_LOC_IRQ] == '0));
endmodule

bind bus_role_ctrl brc_checker #(.N_LOC_IRQ(N_LOC_IRQ), .N_BP_IRQ(N_BP_IRQ)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .role_code_i (role_code_i),
   .dma_req_i   (dma_req_i),
   .arb_gnt_i   (arb_gnt_i),
   .arb_iak_i   (arb_iak_i),
   .bir_wr_i    (bir_wr_i),
   .loc_irq_i   (loc_irq_i),
   .bp_dmr_o    (bp_dmr_o),
   .arb_en_o    (arb_en_o),
   .local_gnt_o (local_gnt_o),
   .bp_sack_o   (bp_sack_o),
   .bp_init_o   (bp_init_o),
   .bp_iak_out_o(bp_iak_out_o),
   .int_rst_o   (int_rst_o),
   .irq_pend_o  (irq_pend_o)
);

// File: tb/bus_role_ctrl_tb_top.sv
module bus_role_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD  = 6;
   localparam int NL    = 3;
   localparam int NB    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] role = 2'd0;
   logic dma_req = 0, arb_gnt = 0, arb_iak = 0, bir_wr = 0;
   logic [NL-1:0] loc_irq = '0;
   logic dmg_in = 0, iak_in = 0, init_in = 0, dcok = 1;
   logic [NB-1:0] bp_irq = '0;
   logic dmr, arb_en, lgnt, sack, binit, iak_out, irst;
   logic [NL+NB-1:0] pend;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_role_ctrl #(.SYNC_STAGES(2), .INIT_HOLD(HOLD), .N_LOC_IRQ(NL), .N_BP_IRQ(NB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .role_code_i(role), .dma_req_i(dma_req),
      .arb_gnt_i(arb_gnt), .arb_iak_i(arb_iak), .bir_wr_i(bir_wr), .loc_irq_i(loc_irq),
      .bp_dmg_in_i(dmg_in), .bp_iak_in_i(iak_in), .bp_init_in_i(init_in),
      .bp_dcok_i(dcok), .bp_irq_i(bp_irq), .bp_dmr_o(dmr), .arb_en_o(arb_en),
      .local_gnt_o(lgnt), .bp_sack_o(sack), .bp_init_o(binit), .bp_iak_out_o(iak_out),
      .int_rst_o(irst), .irq_pend_o(pend)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      // R11: reset holds synchronizers at zero
      role = 2'd1; dmg_in = 1; dma_req = 1;
      tick(3);
      chk("R11 aux grant in reset", lgnt, 0);
      chk("R11 sack in reset", sack, 0);
      chk("R11 int_rst in reset", irst, 1);
      chk("R11 init in reset", binit, 0);
      dmg_in = 0; dma_req = 0; role = 2'd0;
      rst_n = 1;
      tick(HOLD + 6);
      chk("R8 int_rst idle", irst, 0);
      chk("R5 init idle", binit, 0);

      // Sweep: every role against every routed input pattern
      for (int r = 0; r < 4; r++) begin
         for (int p = 0; p < 1024; p++) begin
            logic a;
            role = 2'(r);
            {bp_irq, init_in, iak_in, arb_iak, dmg_in, arb_gnt, dma_req} = 10'(p);
            loc_irq = 3'(p) ^ 3'(p >> 7);
            tick(2);
            a = (r == 0);
            chk("R1 role enable", arb_en, a);
            chk("R2 dma request", dmr, dma_req);
            chk("R3 local grant", lgnt, a ? arb_gnt : dmg_in);
            chk("R4 select ack", sack, !a && dmg_in && dma_req);
            chk("R7 init drive", binit, 0);
            chk("R9 iak out", iak_out, a ? arb_iak : iak_in);
            chk("R8 internal reset", irst, a ? 1'b0 : init_in);
            chk("R10 irq pending", pend, {(a ? bp_irq : 4'b0), loc_irq});
         end
      end
      {bp_irq, init_in, iak_in, arb_iak, dmg_in, arb_gnt, dma_req} = '0;
      loc_irq = '0;

      // R3 / R9: auxiliary latency of exactly two edges
      role = 2'd3;
      tick(3);
      dmg_in = 1; iak_in = 1; init_in = 1;
      tick(1);
      chk("R3 grant after one edge", lgnt, 0);
      chk("R9 iak after one edge", iak_out, 0);
      chk("R8 init_in after one edge", irst, 0);
      tick(1);
      chk("R3 grant after two edges", lgnt, 1);
      chk("R9 iak after two edges", iak_out, 1);
      chk("R8 init_in after two edges", irst, 1);
      dmg_in = 0; iak_in = 0; init_in = 0;
      tick(3);

      // R7: auxiliary never drives init
      begin
         int hi = 0;
         dcok = 0;
         for (int i = 0; i < 8; i++) begin
            bir_wr = (i % 2 == 0);
            tick(1);
            if (binit) hi++;
         end
         bir_wr = 0;
         chk("R7 aux init count", hi, 0);
         chk("R8 aux dcok low reset", irst, 1);
         dcok = 1;
         tick(3);
         chk("R8 aux dcok restored", irst, 0);
      end

      // R5: single write pulse in arbiter role
      role = 2'd0;
      tick(HOLD + 4);
      begin
         int hi = 0;
         bir_wr = 1;
         tick(1);
         bir_wr = 0;
         for (int i = 0; i < 3 * HOLD; i++) begin
            if (binit) hi++;
            if (binit) chk("R8 reset during init", irst, 1);
            tick(1);
         end
         chk("R5 pulse length", hi, HOLD);
      end

      // R5: retrigger three cycles after the first pulse
      begin
         int hi = 0;
         bir_wr = 1;
         tick(1);
         for (int i = 1; i < 4 * HOLD; i++) begin
            if (binit) hi++;
            bir_wr = (i == 3);
            tick(1);
         end
         bir_wr = 0;
         chk("R5 retrigger length", hi, HOLD + 3);
      end

      // R6: DC-OK loss in arbiter role
      dcok = 0;
      tick(2);
      chk("R8 dcok low reset", irst, 1);
      chk("R6 init before third edge", binit, 0);
      tick(1);
      chk("R6 init at third edge", binit, 1);
      tick(5);
      chk("R6 init held while dcok low", binit, 1);
      begin
         int hi = 0;
         dcok = 1;
         tick(1);
         for (int i = 0; i < 3 * HOLD; i++) begin
            if (binit) hi++;
            tick(1);
         end
         chk("R6 tail length", hi, HOLD + 1);
         chk("R8 reset released", irst, 0);
      end

      report();
   end
endmodule